// File: doc/BRIEF.md
# System Control Register Bank

A memory-mapped bank of 32-bit words that occupies a 4 KB byte window on a simple single-cycle register bus. The lower half of the window is backed by general storage, and a few words load fixed identification values at reset. Three identification words return their stored value with two high status bits set when read. The stored content does not change.

The upper half of the window has no storage. A single command offset in that half turns a written code into a one-cycle system reset request or shutdown request. Any other access to the upper half is dropped and produces a one-cycle error pulse. Read data is registered and appears one clock after the read select.

Top module: `sys_ctrl_regs`

## Requirements
- R1: After reset, word index 0x41 (offset 0x104) reads 0x00000002, and words with no preset value read 0. Word index is the byte offset divided by 4.
- R2: Reads of offsets 0x100, 0x108 and 0x10C return the stored word OR 0x30000000. Right after reset they return 0x35F20121, 0x35F30121 and 0x35F40121.
- R3: The OR on read does not alter storage. A word written to 0x100 and then read at 0x100 shows the written value OR 0x30000000. A word written to an unmasked offset reads back exactly as written.
- R4: A full 32-bit write to any offset below 0x800 is stored, and a later read of the same offset returns it. Read data is valid on the cycle after the read select.
- R5: Writing data 1 or 2 to offset 0xF00 gives one pulse on sys_reset_req_o in the cycle after the write.
- R6: Writing data 3 to offset 0xF00 gives one pulse on shutdown_req_o in the cycle after the write. Any other data value at 0xF00 raises neither request. The two requests are never high together.
- R7: Accesses at offsets 0x800 to 0xFFF reach no storage. Reads there return 0 (including a read of 0xF00), and writes there change no stored word.
- R8: An access at offsets 0x800 to 0xFFF gives a one-cycle pulse on access_err_o in the cycle after the access. A write to 0xF00 is exempt and gives no error. Accesses below 0x800 never raise the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Access select, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| sys_reset_req_o | output | 1 | System reset request pulse |
| shutdown_req_o | output | 1 | Shutdown request pulse |
| access_err_o | output | 1 | Out-of-range access pulse |

## Verification
The bench builds the bank with its default parameters: a 12-bit window, 32-bit data and 512 backed words. These values put the storage boundary at 0x7FC/0x800, the command offset at 0xF00 and the top word at 0xFFC within reach of directed accesses. The bench checks that the mask at 0x100/0x108/0x10C is applied on read while storage keeps the written value. It also sends every command code from 0 to 4, plus one large value, to the command offset.

// File: rtl/sys_ctrl_pkg.sv
package sys_ctrl_pkg;
  parameter int unsigned ADDR_W    = 12;
  parameter int unsigned DATA_W    = 32;
  parameter int unsigned NUM_WORDS = 512;

  localparam logic [ADDR_W-1:0] CMD_OFFS  = 12'hF00;
  localparam logic [DATA_W-1:0] READ_MASK = 32'h3000_0000;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'd0,
    CMD_RESET    = 2'd1,
    CMD_SHUTDOWN = 2'd2
  } cmd_e;

  function automatic logic [DATA_W-1:0] preset_val(input int unsigned idx);
    case (idx)
      32'h40:  return 32'h05F2_0121;
      32'h41:  return 32'h0000_0002;
      32'h42:  return 32'h05F3_0121;
      32'h43:  return 32'h05F4_0121;
      default: return '0;
    endcase
  endfunction

  function automatic cmd_e decode_cmd(input logic [DATA_W-1:0] d);
    if (d == 1 || d == 2) return CMD_RESET;
    if (d == 3)           return CMD_SHUTDOWN;
    return CMD_NONE;
  endfunction
endpackage

// File: rtl/sys_ctrl_decode.sv
module sys_ctrl_decode
  import sys_ctrl_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NW = NUM_WORDS,
  localparam int unsigned IW = $clog2(NW)
) (
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output logic          in_range_o,
  output logic [IW-1:0] idx_o,
  output logic          is_cmd_o,
  output logic          mask_hit_o,
  output logic          err_o
);
  logic [AW-3:0] word;
  assign word       = addr_i[AW-1:2];
  assign in_range_o = (32'(word) < NW);
  assign idx_o      = word[IW-1:0];
  assign is_cmd_o   = sel_i && we_i && (addr_i == CMD_OFFS);
  assign mask_hit_o = in_range_o &&
                      (32'(word) == 32'h40 || 32'(word) == 32'h42 || 32'(word) == 32'h43);
  assign err_o      = sel_i && !in_range_o && !is_cmd_o;
endmodule

// File: rtl/sys_ctrl_store.sv
module sys_ctrl_store
  import sys_ctrl_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NW = NUM_WORDS,
  localparam int unsigned IW = $clog2(NW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rword_o
);
  logic [DW-1:0] mem [NW];

  for (genvar g = 0; g < NW; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         mem[g] <= preset_val(g);
      else if (wr_i && idx_i == IW'(g))    mem[g] <= wdata_i;
    end
  end

  assign rword_o = mem[idx_i];
endmodule

// File: rtl/sys_ctrl_cmd.sv
module sys_ctrl_cmd
  import sys_ctrl_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          reset_req_o,
  output logic          shutdown_req_o
);
  cmd_e c;
  assign c = decode_cmd(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reset_req_o    <= 1'b0;
      shutdown_req_o <= 1'b0;
    end else begin
      reset_req_o    <= cmd_wr_i && (c == CMD_RESET);
      shutdown_req_o <= cmd_wr_i && (c == CMD_SHUTDOWN);
    end
  end

  p_req_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reset_req_o && shutdown_req_o));
  p_req_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |=> !reset_req_o || $past(cmd_wr_i));
endmodule

// File: rtl/sys_ctrl_regs.sv
module sys_ctrl_regs
  import sys_ctrl_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NW = NUM_WORDS,
  localparam int unsigned IW = $clog2(NW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          sys_reset_req_o,
  output logic          shutdown_req_o,
  output logic          access_err_o
);
  logic          in_range, is_cmd, mask_hit, err_c;
  logic [IW-1:0] idx;
  logic [DW-1:0] rword;

  sys_ctrl_decode #(.AW(AW), .NW(NW)) u_dec (
    .sel_i, .we_i, .addr_i,
    .in_range_o(in_range), .idx_o(idx), .is_cmd_o(is_cmd),
    .mask_hit_o(mask_hit), .err_o(err_c)
  );

  sys_ctrl_store #(.DW(DW), .NW(NW)) u_store (
    .clk_i, .rst_ni,
    .wr_i(sel_i && we_i && in_range),
    .idx_i(idx), .wdata_i, .rword_o(rword)
  );

  sys_ctrl_cmd #(.DW(DW)) u_cmd (
    .clk_i, .rst_ni, .cmd_wr_i(is_cmd), .wdata_i,
    .reset_req_o(sys_reset_req_o), .shutdown_req_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o      <= '0;
      access_err_o <= 1'b0;
    end else begin
      access_err_o <= err_c;
      if (sel_i && !we_i)
        rdata_o <= in_range ? (rword | (mask_hit ? READ_MASK : '0)) : '0;
    end
  end

  p_err_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_err_o |-> $past(sel_i) && $past(addr_i[AW-1]));
  p_no_cmd_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_reset_req_o || shutdown_req_o) |-> !access_err_o);
  p_oor_read_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && addr_i[AW-1]) |=> rdata_o == '0);
  p_mask_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && (addr_i == 12'h100 || addr_i == 12'h108 || addr_i == 12'h10C))
      |=> (rdata_o[29:28] == 2'b11));
endmodule

// File: tb/sys_ctrl_regs_bench.sv
module sys_ctrl_regs_bench;
  logic        clk = 0, rst_n = 0, sel = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rreq, sreq, err;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sys_ctrl_regs u_sys_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sys_reset_req_o(rreq),
    .shutdown_req_o(sreq), .access_err_o(err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one access; flags sampled at the next negedge (cycle after)
  task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic [2:0] fl);
    sel = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
    rd = rdata; fl = {rreq, sreq, err};
    @(negedge clk);
    chk("pulse one cycle", {29'd0, rreq, sreq, err}, 32'd0);
  endtask

  logic [31:0] rd; logic [2:0] fl;

  task automatic t_reset_vals();
    acc(0, 12'h104, 0, rd, fl); chk("R1 0x104", rd, 32'h2);
    acc(0, 12'h000, 0, rd, fl); chk("R1 0x000", rd, 0);
    acc(0, 12'h7FC, 0, rd, fl); chk("R1 0x7FC", rd, 0);
    acc(0, 12'h100, 0, rd, fl); chk("R2 0x100", rd, 32'h35F20121);
    acc(0, 12'h108, 0, rd, fl); chk("R2 0x108", rd, 32'h35F30121);
    acc(0, 12'h10C, 0, rd, fl); chk("R2 0x10C", rd, 32'h35F40121);
  endtask

  task automatic t_write_read();
    acc(1, 12'h010, 32'hDEADBEEF, rd, fl); chk("R8 no err in range", fl, 0);
    acc(0, 12'h010, 0, rd, fl); chk("R4 rd 0x010", rd, 32'hDEADBEEF);
    acc(1, 12'h7FC, 32'hA5A5_0001, rd, fl);
    acc(0, 12'h7FC, 0, rd, fl); chk("R4 rd 0x7FC", rd, 32'hA5A50001);
    acc(1, 12'h100, 32'h0000_00FF, rd, fl);
    acc(0, 12'h100, 0, rd, fl); chk("R3 masked 0x100", rd, 32'h300000FF);
    acc(1, 12'h104, 32'h3000_0000, rd, fl);
    acc(1, 12'h104, 32'h0000_1234, rd, fl);
    acc(0, 12'h104, 0, rd, fl); chk("R3 unmasked 0x104", rd, 32'h1234);
  endtask

  task automatic t_oor();
    acc(1, 12'h800, 32'h1111_1111, rd, fl); chk("R8 err wr 0x800", fl, 3'b001);
    acc(0, 12'h000, 0, rd, fl); chk("R7 alias untouched", rd, 0);
    acc(0, 12'h800, 0, rd, fl); chk("R7 rd 0x800", rd, 0); chk("R8 err rd", fl, 3'b001);
    acc(1, 12'hFFC, 32'h10, rd, fl); chk("R8 err 0xFFC", fl, 3'b001);
    acc(0, 12'h7FC, 0, rd, fl); chk("R7 0x7FC kept", rd, 32'hA5A50001);
  endtask

  task automatic t_cmd();
    acc(1, 12'hF00, 1, rd, fl); chk("R5 code1", fl, 3'b100);
    acc(1, 12'hF00, 2, rd, fl); chk("R5 code2", fl, 3'b100);
    acc(1, 12'hF00, 3, rd, fl); chk("R6 code3", fl, 3'b010);
    acc(1, 12'hF00, 0, rd, fl); chk("R6 code0", fl, 3'b000);
    acc(1, 12'hF00, 4, rd, fl); chk("R6 code4", fl, 3'b000);
    acc(1, 12'hF00, 32'h1_0001, rd, fl); chk("R6 big", fl, 3'b000);
    acc(1, 12'hF04, 1, rd, fl); chk("R8 near cmd", fl, 3'b001);
    acc(0, 12'hF00, 0, rd, fl); chk("R7 rd 0xF00", rd, 0); chk("R8 rd 0xF00 err", fl, 3'b001);
  endtask

  initial begin
    #3000000;
    fails++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {rdata[3:0], rreq, sreq, err}, 0);
    rst_n = 1;
    @(negedge clk);
    t_reset_vals();
    t_write_read();
    t_oor();
    t_cmd();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule